// File: doc/BRIEF.md
# Video Overlay Blend Mixer

This block sits at the end of a video output path. It merges a live video pixel stream with a graphics overlay pixel stream and sends the result out as a multiplexed 8-bit 4:2:2 YUV byte stream. Each input cycle carries one pixel of each layer: luma, a chroma pair, and a per-pixel overlay weight from 0 to 128. Because the top weight is 128, a pixel can be pure video or pure graphics with no rounding error. A line-start flag and a frame-start flag mark where each line and frame begins. From these flags the block derives the pixel's column and row, so it knows whether the pixel falls inside the overlay rectangle.

Inside the rectangle the weight is applied per component. If a graphics pixel matches a programmed key colour, it is treated as transparent. Completed pixel pairs are clamped to per-component limits. They can also be widened two times horizontally, either by repeating samples or by interpolating them. The pairs are queued in a small word buffer and sent out one byte per cycle. Configuration is captured from a set of input pins on a load strobe. Reset sets a configuration that passes video through unchanged.

Top module: `ovl_mixer`

## Requirements
- R1: Each component is computed as (a*G + (128-a)*V + 64) >> 7, where a is the effective weight, G the graphics value and V the video value. a=0 gives exactly V and a=128 gives exactly G.
- R2: A weight input above 128 gives the same result as 128.
- R3: Pixel pairs start at an even column. The output chroma of a pair is blended from the even pixel's U and V using the even pixel's weight. The U and V inputs of the odd pixel have no effect.
- R4: When keying is enabled, a pixel is keyed if its graphics luma equals the key luma and the graphics U and V of its pair's even pixel equal the key chroma. A keyed pixel shows video (weight forced to 0).
- R5: Column and row are counted from the line-start and frame-start flags, both starting at 0. Outside the inclusive rectangle [x0..x1] x [y0..y1] the weight is forced to 0.
- R6: Every output byte is clamped to its component's [min, max] range.
- R7: Each pixel pair leaves as four bytes on consecutive cycles in the order U, Y0, V, Y1.
- R8: In repeat upscale mode, a pair (Y0, Y1, U, V) becomes two pairs: (U, Y0, V, Y0) and (U, Y1, V, Y1).
- R9: In interpolate upscale mode, a pair becomes (avg(Cp,C), avg(Yp,Y0), Y0) followed by (C, avg(Y0,Y1), Y1). Here avg(a,b) = (a+b+1)>>1, and Yp and Cp are the last luma and the chroma of the previous pair on the same line, or the pair's own values at the start of a line.
- R10: During and after reset the output is idle. The configuration returns to: full-frame rectangle, keying off, limits 0 and 255, upscaling off.
- R11: With an input pixel at most every 2 cycles (every 4 cycles when upscaling), no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures all cfg_* pins into the configuration registers |
| cfg_win_x0 | input | X_W | Overlay first column |
| cfg_win_x1 | input | X_W | Overlay last column |
| cfg_win_y0 | input | Y_W | Overlay first row |
| cfg_win_y1 | input | Y_W | Overlay last row |
| cfg_key_en | input | 1 | Enables colour keying |
| cfg_key_y | input | 8 | Key luma |
| cfg_key_u | input | 8 | Key U |
| cfg_key_v | input | 8 | Key V |
| cfg_y_min | input | 8 | Luma lower limit |
| cfg_y_max | input | 8 | Luma upper limit |
| cfg_u_min | input | 8 | U lower limit |
| cfg_u_max | input | 8 | U upper limit |
| cfg_v_min | input | 8 | V lower limit |
| cfg_v_max | input | 8 | V upper limit |
| cfg_up_en | input | 1 | Enables 2X horizontal upscaling |
| cfg_up_interp | input | 1 | Selects interpolation (1) or repetition (0) |
| in_vld | input | 1 | Input pixel valid |
| in_sol | input | 1 | Pixel is the first of a line |
| in_sof | input | 1 | Pixel is the first of a frame |
| vid_y | input | 8 | Video luma |
| vid_u | input | 8 | Video U |
| vid_v | input | 8 | Video V |
| gfx_y | input | 8 | Graphics luma |
| gfx_u | input | 8 | Graphics U |
| gfx_v | input | 8 | Graphics V |
| gfx_a | input | 8 | Graphics weight, 0..128 |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Multiplexed 4:2:2 byte |

## Verification
Two properties are checked on every cycle: each output byte stays within the limits of its component slot, and a started four-byte group is never interrupted. Two more are also checked on every cycle: no word is written into a full queue, and the output is quiet right after reset. The bench's scenarios are the only evidence for the arithmetic, the use of the even pixel's weight, keying against the stored pair chroma, the rectangle edges, and both upscale patterns. All of these depend on values computed across several pixels, which a single-cycle property cannot relate.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int PIX_W   = 8;
  localparam int ALPHA_W = 8;
  localparam int ASH     = 7;
  localparam int ACC_W   = PIX_W + ALPHA_W + 1;
  localparam logic [ALPHA_W-1:0] A_FULL = ALPHA_W'(1 << ASH);

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t y_lo; pix_t y_hi;
    pix_t u_lo; pix_t u_hi;
    pix_t v_lo; pix_t v_hi;
  } clip_t;

  typedef struct packed {
    logic en;
    pix_t y; pix_t u; pix_t v;
  } key_t;

  typedef struct packed {
    logic en;
    logic interp;
  } up_t;

  typedef struct packed {
    pix_t u; pix_t ya; pix_t v; pix_t yb;
  } word_t;

  function automatic pix_t blend(input logic [ALPHA_W-1:0] a, input pix_t g, input pix_t v);
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(a) * ACC_W'(g) + (ACC_W'(A_FULL) - ACC_W'(a)) * ACC_W'(v)
        + ACC_W'(A_FULL >> 1);
    return acc[ASH+PIX_W-1:ASH];
  endfunction

  function automatic pix_t avg2(input pix_t a, input pix_t b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    return s[PIX_W:1];
  endfunction

  function automatic pix_t clamp(input pix_t x, input pix_t lo, input pix_t hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic word_t clip_word(input word_t w, input clip_t c);
    word_t r;
    r.u  = clamp(w.u,  c.u_lo, c.u_hi);
    r.ya = clamp(w.ya, c.y_lo, c.y_hi);
    r.v  = clamp(w.v,  c.v_lo, c.v_hi);
    r.yb = clamp(w.yb, c.y_lo, c.y_hi);
    return r;
  endfunction
endpackage

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic               in_sol,
  input  logic               in_sof,
  input  pix_t               vid_y,
  input  pix_t               vid_u,
  input  pix_t               vid_v,
  input  pix_t               gfx_y,
  input  pix_t               gfx_u,
  input  pix_t               gfx_v,
  input  logic [ALPHA_W-1:0] gfx_a,
  input  logic [X_W-1:0]     win_x0,
  input  logic [X_W-1:0]     win_x1,
  input  logic [Y_W-1:0]     win_y0,
  input  logic [Y_W-1:0]     win_y1,
  input  key_t               key,
  output logic               s1_vld,
  output logic               s1_odd,
  output logic               s1_sol,
  output pix_t               s1_y,
  output pix_t               s1_u,
  output pix_t               s1_v
);
  logic [X_W-1:0]     x_cnt, cur_x;
  logic [Y_W-1:0]     y_cnt, cur_y;
  pix_t               even_gu, even_gv, pair_gu, pair_gv;
  logic               line_start, odd, in_win, keyed;
  logic [ALPHA_W-1:0] a_sat, a_eff;

  always_comb begin
    line_start = in_sol | in_sof;
    cur_x      = line_start ? '0 : x_cnt;
    if (in_sof)      cur_y = '0;
    else if (in_sol) cur_y = y_cnt + Y_W'(1);
    else             cur_y = y_cnt;
    odd     = cur_x[0];
    pair_gu = odd ? even_gu : gfx_u;
    pair_gv = odd ? even_gv : gfx_v;
    in_win  = (cur_x >= win_x0) && (cur_x <= win_x1) &&
              (cur_y >= win_y0) && (cur_y <= win_y1);
    keyed   = key.en && (gfx_y == key.y) && (pair_gu == key.u) && (pair_gv == key.v);
    a_sat   = (gfx_a > A_FULL) ? A_FULL : gfx_a;
    a_eff   = (in_win && !keyed) ? a_sat : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cnt   <= '0;
      y_cnt   <= '0;
      even_gu <= '0;
      even_gv <= '0;
      s1_vld  <= 1'b0;
      s1_odd  <= 1'b0;
      s1_sol  <= 1'b0;
      s1_y    <= '0;
      s1_u    <= '0;
      s1_v    <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        x_cnt  <= cur_x + X_W'(1);
        y_cnt  <= cur_y;
        if (!odd) begin
          even_gu <= gfx_u;
          even_gv <= gfx_v;
        end
        s1_odd <= odd;
        s1_sol <= line_start;
        s1_y   <= blend(a_eff, gfx_y, vid_y);
        s1_u   <= blend(a_eff, gfx_u, vid_u);
        s1_v   <= blend(a_eff, gfx_v, vid_v);
      end
    end
  end
endmodule

// File: rtl/ovl_pair_fmt.sv
module ovl_pair_fmt
  import ovl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  s1_vld,
  input  logic  s1_odd,
  input  logic  s1_sol,
  input  pix_t  s1_y,
  input  pix_t  s1_u,
  input  pix_t  s1_v,
  input  up_t   up,
  input  clip_t clip,
  output logic  push,
  output word_t wdata
);
  pix_t  e_y, e_u, e_v, prev_y, prev_u, prev_v;
  pix_t  py, pu, pv;
  logic  e_sol, b_pend, pair_done;
  word_t wa, wb, wn, b_word;

  always_comb begin
    pair_done = s1_vld && s1_odd;
    py = e_sol ? e_y : prev_y;
    pu = e_sol ? e_u : prev_u;
    pv = e_sol ? e_v : prev_v;
    wn = '{u: e_u, ya: e_y, v: e_v, yb: s1_y};
    if (up.interp) begin
      wa = '{u: avg2(pu, e_u), ya: avg2(py, e_y), v: avg2(pv, e_v), yb: e_y};
      wb = '{u: e_u, ya: avg2(e_y, s1_y), v: e_v, yb: s1_y};
    end else begin
      wa = '{u: e_u, ya: e_y, v: e_v, yb: e_y};
      wb = '{u: e_u, ya: s1_y, v: e_v, yb: s1_y};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push   <= 1'b0;
      wdata  <= '0;
      b_pend <= 1'b0;
      b_word <= '0;
      e_y    <= '0;
      e_u    <= '0;
      e_v    <= '0;
      e_sol  <= 1'b0;
      prev_y <= '0;
      prev_u <= '0;
      prev_v <= '0;
    end else begin
      push <= 1'b0;
      if (s1_vld && !s1_odd) begin
        e_y   <= s1_y;
        e_u   <= s1_u;
        e_v   <= s1_v;
        e_sol <= s1_sol;
      end
      if (pair_done) begin
        push   <= 1'b1;
        prev_y <= s1_y;
        prev_u <= e_u;
        prev_v <= e_v;
        if (up.en) begin
          wdata  <= clip_word(wa, clip);
          b_word <= clip_word(wb, clip);
          b_pend <= 1'b1;
        end else begin
          wdata  <= clip_word(wn, clip);
        end
      end else if (b_pend) begin
        push   <= 1'b1;
        wdata  <= b_word;
        b_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ovl_fifo_ser.sv
module ovl_fifo_ser
  import ovl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  word_t wdata,
  output logic  full,
  output logic  out_vld,
  output pix_t  out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  word_t         mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          empty, pop, busy;
  logic [1:0]    idx;
  word_t         cur;
  pix_t          sel;

  always_comb begin
    empty = (wr_ptr == rd_ptr);
    full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    pop   = !empty && (!busy || idx == 2'd3);
    case (idx)
      2'd0:    sel = cur.u;
      2'd1:    sel = cur.ya;
      2'd2:    sel = cur.v;
      default: sel = cur.yb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      busy     <= 1'b0;
      idx      <= 2'd0;
      cur      <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= 1'b0;
      if (push && !full) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (busy) begin
        out_vld  <= 1'b1;
        out_data <= sel;
        idx      <= idx + 2'd1;
        if (idx == 2'd3) busy <= 1'b0;
      end
      if (pop) begin
        cur    <= mem[rd_ptr[AW-1:0]];
        busy   <= 1'b1;
        rd_ptr <= rd_ptr + (AW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
  import ovl_pkg::*;
#(
  parameter int X_W        = 12,
  parameter int Y_W        = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_load,
  input  logic [X_W-1:0] cfg_win_x0,
  input  logic [X_W-1:0] cfg_win_x1,
  input  logic [Y_W-1:0] cfg_win_y0,
  input  logic [Y_W-1:0] cfg_win_y1,
  input  logic           cfg_key_en,
  input  logic [7:0]     cfg_key_y,
  input  logic [7:0]     cfg_key_u,
  input  logic [7:0]     cfg_key_v,
  input  logic [7:0]     cfg_y_min,
  input  logic [7:0]     cfg_y_max,
  input  logic [7:0]     cfg_u_min,
  input  logic [7:0]     cfg_u_max,
  input  logic [7:0]     cfg_v_min,
  input  logic [7:0]     cfg_v_max,
  input  logic           cfg_up_en,
  input  logic           cfg_up_interp,
  input  logic           in_vld,
  input  logic           in_sol,
  input  logic           in_sof,
  input  logic [7:0]     vid_y,
  input  logic [7:0]     vid_u,
  input  logic [7:0]     vid_v,
  input  logic [7:0]     gfx_y,
  input  logic [7:0]     gfx_u,
  input  logic [7:0]     gfx_v,
  input  logic [7:0]     gfx_a,
  output logic           out_vld,
  output logic [7:0]     out_data
);
  logic [X_W-1:0] win_x0_q, win_x1_q;
  logic [Y_W-1:0] win_y0_q, win_y1_q;
  key_t           key_q;
  clip_t          clip_q;
  up_t            up_q;

  logic  s1_vld, s1_odd, s1_sol;
  pix_t  s1_y, s1_u, s1_v;
  logic  fmt_push, fifo_full;
  word_t fmt_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_x0_q <= '0;
      win_x1_q <= '1;
      win_y0_q <= '0;
      win_y1_q <= '1;
      key_q    <= '0;
      clip_q   <= '{y_lo: '0, y_hi: '1, u_lo: '0, u_hi: '1, v_lo: '0, v_hi: '1};
      up_q     <= '0;
    end else if (cfg_load) begin
      win_x0_q <= cfg_win_x0;
      win_x1_q <= cfg_win_x1;
      win_y0_q <= cfg_win_y0;
      win_y1_q <= cfg_win_y1;
      key_q    <= '{en: cfg_key_en, y: cfg_key_y, u: cfg_key_u, v: cfg_key_v};
      clip_q   <= '{y_lo: cfg_y_min, y_hi: cfg_y_max, u_lo: cfg_u_min,
                    u_hi: cfg_u_max, v_lo: cfg_v_min, v_hi: cfg_v_max};
      up_q     <= '{en: cfg_up_en, interp: cfg_up_interp};
    end
  end

  ovl_blend #(.X_W(X_W), .Y_W(Y_W)) u_blend (
    .clk(clk), .rst(rst),
    .in_vld(in_vld), .in_sol(in_sol), .in_sof(in_sof),
    .vid_y(vid_y), .vid_u(vid_u), .vid_v(vid_v),
    .gfx_y(gfx_y), .gfx_u(gfx_u), .gfx_v(gfx_v), .gfx_a(gfx_a),
    .win_x0(win_x0_q), .win_x1(win_x1_q), .win_y0(win_y0_q), .win_y1(win_y1_q),
    .key(key_q),
    .s1_vld(s1_vld), .s1_odd(s1_odd), .s1_sol(s1_sol),
    .s1_y(s1_y), .s1_u(s1_u), .s1_v(s1_v)
  );

  ovl_pair_fmt u_fmt (
    .clk(clk), .rst(rst),
    .s1_vld(s1_vld), .s1_odd(s1_odd), .s1_sol(s1_sol),
    .s1_y(s1_y), .s1_u(s1_u), .s1_v(s1_v),
    .up(up_q), .clip(clip_q),
    .push(fmt_push), .wdata(fmt_word)
  );

  ovl_fifo_ser #(.DEPTH(FIFO_DEPTH)) u_ser (
    .clk(clk), .rst(rst),
    .push(fmt_push), .wdata(fmt_word), .full(fifo_full),
    .out_vld(out_vld), .out_data(out_data)
  );
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk
  import ovl_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       out_vld,
  input logic [7:0] out_data,
  input logic       fifo_push,
  input logic       fifo_full,
  input clip_t      clip
);
  logic [1:0] ph;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)          ph <= 2'd0;
    else if (out_vld) ph <= ph + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst_d == 1'b1) a_r10_reset_quiet: assert (!out_vld);
  end

  a_r7_group_unbroken: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ph != 2'd3) |=> out_vld);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(fifo_push && fifo_full));

  a_r6_luma_in_range: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ph[0]) |-> (out_data >= clip.y_lo && out_data <= clip.y_hi));

  a_r6_u_in_range: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ph == 2'd0) |-> (out_data >= clip.u_lo && out_data <= clip.u_hi));

  a_r6_v_in_range: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ph == 2'd2) |-> (out_data >= clip.v_lo && out_data <= clip.v_hi));
endmodule

bind ovl_mixer ovl_mixer_chk u_chk (
  .clk(clk), .rst(rst), .out_vld(out_vld), .out_data(out_data),
  .fifo_push(fmt_push), .fifo_full(fifo_full), .clip(clip_q)
);

// File: tb/ovl_mixer_tb.sv
module ovl_mixer_tb;
  localparam int X_W = 12;
  localparam int Y_W = 12;
  localparam int NV  = 7;
  // fields: vy0 vy1 vu vv gy0 gy1 gu gv a0 a1 | expected U Y0 V Y1
  localparam logic [111:0] VEC [NV] = '{
    {8'd16,  8'd235, 8'd128, 8'd128, 8'd200, 8'd50,  8'd90,  8'd60,  8'd0,   8'd0,   8'd128, 8'd16,  8'd128, 8'd235},
    {8'd16,  8'd235, 8'd128, 8'd128, 8'd200, 8'd50,  8'd90,  8'd60,  8'd128, 8'd128, 8'd90,  8'd200, 8'd60,  8'd50},
    {8'd100, 8'd0,   8'd10,  8'd255, 8'd200, 8'd255, 8'd20,  8'd0,   8'd64,  8'd64,  8'd15,  8'd150, 8'd128, 8'd128},
    {8'd1,   8'd2,   8'd3,   8'd4,   8'd9,   8'd8,   8'd7,   8'd6,   8'd200, 8'd255, 8'd7,   8'd9,   8'd6,   8'd8},
    {8'd50,  8'd60,  8'd70,  8'd80,  8'd150, 8'd160, 8'd170, 8'd180, 8'd0,   8'd128, 8'd70,  8'd50,  8'd80,  8'd160},
    {8'd50,  8'd60,  8'd70,  8'd80,  8'd150, 8'd160, 8'd170, 8'd180, 8'd128, 8'd0,   8'd170, 8'd150, 8'd180, 8'd60},
    {8'd0,   8'd255, 8'd0,   8'd128, 8'd255, 8'd0,   8'd128, 8'd0,   8'd1,   8'd127, 8'd1,   8'd2,   8'd127, 8'd2}
  };
  localparam string VTAG [NV] = '{"R1", "R1", "R1", "R2", "R3", "R3", "R1"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [X_W-1:0] cfg_win_x0, cfg_win_x1;
  logic [Y_W-1:0] cfg_win_y0, cfg_win_y1;
  logic cfg_key_en, cfg_up_en, cfg_up_interp;
  logic [7:0] cfg_key_y, cfg_key_u, cfg_key_v;
  logic [7:0] cfg_y_min, cfg_y_max, cfg_u_min, cfg_u_max, cfg_v_min, cfg_v_max;
  logic in_vld = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [7:0] vid_y = '0, vid_u = '0, vid_v = '0;
  logic [7:0] gfx_y = '0, gfx_u = '0, gfx_v = '0, gfx_a = '0;
  logic out_vld;
  logic [7:0] out_data;

  int checks = 0, errors = 0, ocnt = 0, rd = 0;
  logic [7:0] obuf [0:255];
  bit done = 0;

  always #2.5 clk = ~clk;

  ovl_mixer #(.X_W(X_W), .Y_W(Y_W), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_win_x0(cfg_win_x0), .cfg_win_x1(cfg_win_x1),
    .cfg_win_y0(cfg_win_y0), .cfg_win_y1(cfg_win_y1),
    .cfg_key_en(cfg_key_en), .cfg_key_y(cfg_key_y), .cfg_key_u(cfg_key_u), .cfg_key_v(cfg_key_v),
    .cfg_y_min(cfg_y_min), .cfg_y_max(cfg_y_max), .cfg_u_min(cfg_u_min),
    .cfg_u_max(cfg_u_max), .cfg_v_min(cfg_v_min), .cfg_v_max(cfg_v_max),
    .cfg_up_en(cfg_up_en), .cfg_up_interp(cfg_up_interp),
    .in_vld(in_vld), .in_sol(in_sol), .in_sof(in_sof),
    .vid_y(vid_y), .vid_u(vid_u), .vid_v(vid_v),
    .gfx_y(gfx_y), .gfx_u(gfx_u), .gfx_v(gfx_v), .gfx_a(gfx_a),
    .out_vld(out_vld), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (out_vld === 1'b1) begin
      obuf[ocnt[7:0]] = out_data;
      ocnt++;
    end
  end

  task automatic cfg_defaults();
    cfg_win_x0 = '0; cfg_win_x1 = '1; cfg_win_y0 = '0; cfg_win_y1 = '1;
    cfg_key_en = 0; cfg_key_y = 0; cfg_key_u = 0; cfg_key_v = 0;
    cfg_y_min = 0; cfg_y_max = 255; cfg_u_min = 0; cfg_u_max = 255;
    cfg_v_min = 0; cfg_v_max = 255; cfg_up_en = 0; cfg_up_interp = 0;
  endtask

  task automatic load_cfg();
    @(negedge clk); cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic send_pix(input logic sol, input logic sof,
                          input logic [7:0] vy, input logic [7:0] vu, input logic [7:0] vv,
                          input logic [7:0] gy, input logic [7:0] gu, input logic [7:0] gv,
                          input logic [7:0] a);
    @(negedge clk);
    in_vld = 1'b1; in_sol = sol; in_sof = sof;
    vid_y = vy; vid_u = vu; vid_v = vv;
    gfx_y = gy; gfx_u = gu; gfx_v = gv; gfx_a = a;
    @(negedge clk);
    in_vld = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect4(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input logic [7:0] e3);
    int t;
    logic [31:0] act, exp_w;
    t = 0;
    while (ocnt < rd + 4 && t < 200) begin
      @(negedge clk);
      t++;
    end
    exp_w = {e0, e1, e2, e3};
    if (ocnt < rd + 4) act = 32'hxxxxxxxx;
    else act = {obuf[rd[7:0]], obuf[8'(rd+1)], obuf[8'(rd+2)], obuf[8'(rd+3)]};
    checks++;
    if (act !== exp_w) begin
      errors++;
      $display("FAIL %s: bytes U,Y0,V,Y1 actual %h expected %h", tag, act, exp_w);
    end
    rd += 4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    bit quiet;
    cfg_defaults();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: idle output after reset
    quiet = 1;
    repeat (6) begin
      @(negedge clk);
      if (out_vld !== 1'b0) quiet = 0;
    end
    checks++;
    if (!quiet) begin errors++; $display("FAIL R10: out_vld actual 1 expected 0"); end

    // R1 R2 R3 R7: table walk, odd-pixel chroma set to junk
    for (int i = 0; i < NV; i++) begin
      logic [111:0] v;
      v = VEC[i];
      send_pix(1'b1, 1'b0, v[111:104], v[95:88], v[87:80], v[79:72], v[63:56], v[55:48], v[47:40]);
      send_pix(1'b0, 1'b0, v[103:96], 8'h5A, 8'h5A, v[71:64], 8'h5A, 8'h5A, v[39:32]);
      expect4({VTAG[i], "/R7 vector"}, v[31:24], v[23:16], v[15:8], v[7:0]);
    end

    // R6: clamping
    cfg_y_min = 16; cfg_y_max = 235; cfg_u_min = 16; cfg_u_max = 240;
    cfg_v_min = 16; cfg_v_max = 240;
    load_cfg();
    send_pix(1'b1, 1'b0, 8'd0, 8'd0, 8'd255, 8'd9, 8'd9, 8'd9, 8'd0);
    send_pix(1'b0, 1'b0, 8'd255, 8'd0, 8'd0, 8'd9, 8'd9, 8'd9, 8'd0);
    expect4("R6 clamp", 8'd16, 8'd16, 8'd240, 8'd235);

    // R10: reset restores transparent limits
    repeat (10) @(negedge clk);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    cfg_defaults();
    send_pix(1'b1, 1'b1, 8'd0, 8'd0, 8'd255, 8'd9, 8'd9, 8'd9, 8'd0);
    send_pix(1'b0, 1'b0, 8'd255, 8'd0, 8'd0, 8'd9, 8'd9, 8'd9, 8'd0);
    expect4("R10 defaults", 8'd0, 8'd0, 8'd255, 8'd255);

    // R4: keying, odd pixel keyed against the even pixel's graphics chroma
    cfg_key_en = 1; cfg_key_y = 10; cfg_key_u = 20; cfg_key_v = 30;
    load_cfg();
    send_pix(1'b1, 1'b0, 8'd100, 8'd50, 8'd60, 8'd10, 8'd20, 8'd30, 8'd128);
    send_pix(1'b0, 1'b0, 8'd110, 8'h5A, 8'h5A, 8'd10, 8'h5A, 8'h5A, 8'd128);
    expect4("R4 both keyed", 8'd50, 8'd100, 8'd60, 8'd110);
    send_pix(1'b1, 1'b0, 8'd100, 8'd50, 8'd60, 8'd10, 8'd20, 8'd30, 8'd128);
    send_pix(1'b0, 1'b0, 8'd110, 8'h5A, 8'h5A, 8'd11, 8'h5A, 8'h5A, 8'd128);
    expect4("R4 odd unkeyed", 8'd50, 8'd100, 8'd60, 8'd11);
    cfg_key_en = 0;

    // R5: rectangle columns 2..3, row 1 only
    cfg_win_x0 = 2; cfg_win_x1 = 3; cfg_win_y0 = 1; cfg_win_y1 = 1;
    load_cfg();
    for (int ln = 0; ln < 2; ln++) begin
      for (int px = 0; px < 4; px++) begin
        send_pix(px == 0, (ln == 0) && (px == 0), 8'(10 + px), 8'd20, 8'd30,
                 8'(200 + px), 8'd220, 8'd230, 8'd128);
      end
    end
    expect4("R5 row0 left", 8'd20, 8'd10, 8'd30, 8'd11);
    expect4("R5 row0 right", 8'd20, 8'd12, 8'd30, 8'd13);
    expect4("R5 row1 left", 8'd20, 8'd10, 8'd30, 8'd11);
    expect4("R5 row1 inside", 8'd220, 8'd202, 8'd230, 8'd203);
    cfg_defaults();

    // R8: repeat upscale
    cfg_up_en = 1; cfg_up_interp = 0;
    load_cfg();
    send_pix(1'b1, 1'b0, 8'd40, 8'd100, 8'd200, 8'd0, 8'd0, 8'd0, 8'd0);
    send_pix(1'b0, 1'b0, 8'd80, 8'h5A, 8'h5A, 8'd0, 8'd0, 8'd0, 8'd0);
    expect4("R8 first", 8'd100, 8'd40, 8'd200, 8'd40);
    expect4("R8 second", 8'd100, 8'd80, 8'd200, 8'd80);

    // R9 R11: interpolated upscale over two pairs at the fastest allowed rate
    cfg_up_interp = 1;
    load_cfg();
    send_pix(1'b1, 1'b0, 8'd40, 8'd100, 8'd200, 8'd0, 8'd0, 8'd0, 8'd0);
    send_pix(1'b0, 1'b0, 8'd80, 8'h5A, 8'h5A, 8'd0, 8'd0, 8'd0, 8'd0);
    send_pix(1'b0, 1'b0, 8'd120, 8'd110, 8'd210, 8'd0, 8'd0, 8'd0, 8'd0);
    send_pix(1'b0, 1'b0, 8'd160, 8'h5A, 8'h5A, 8'd0, 8'd0, 8'd0, 8'd0);
    expect4("R9 line start A", 8'd100, 8'd40, 8'd200, 8'd40);
    expect4("R9 line start B", 8'd100, 8'd60, 8'd200, 8'd80);
    expect4("R9 mid A", 8'd105, 8'd100, 8'd205, 8'd120);
    expect4("R11 R9 mid B", 8'd110, 8'd140, 8'd210, 8'd160);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule